// File: doc/BRIEF.md
# Multi-Core Debug Halt Synchronizer

This block ties together the debug halt state of up to eight processor cores so that the cores in a group stop as one. Each core reports, on its own halted line, that it has entered debug state (after a breakpoint or an exception, say). Each core also receives a stop line from this block that forces it into debug state. The host debugger assigns cores to as many as four groups by writing membership masks into a small register file. When any member of a group halts, the group latches a sticky trigger flag and drives stop to every member. Stop stays high until software clears the flag.

The halted lines come from other clock domains, so they pass through a two-flop synchronizer before use. A core may sit in several groups. Its stop line is the OR of the requests from every triggered group that contains it. A global enable bit gates the whole mechanism. For each group the block records which core caused the trigger, taking the lowest-numbered one when several halt in the same cycle, so the debugger can tell which core stopped first.

Register map (word addresses, `addr` is 4 bits wide). Address 0 is the control register: bit 0 is the global enable, readable and writable. Address 1+g is the register of group g (g = 0..3). On write, bits [7:0] load the membership mask and bit 8 = 1 clears the trigger flag. On read, bits [7:0] return the mask, bit 8 the trigger flag, and bits [12:10] the cause index. Reads are combinational while `rd_en` is high, and `rdata` is zero otherwise.

Top module: `halt_sync_xtrig`

## Requirements
- R1: After reset every mask is zero, every trigger flag and cause is zero, enable is clear, `stop_out` is all zeros, and a read of any register returns zero.
- R2: With enable set and a core in group g, a rise of that core's `halt_in` bit, applied before a clock edge, raises `stop_out` for the group's members after exactly the third rising edge and not sooner.
- R3: When any member of a triggered group halts, the block drives stop to every core whose bit is set in that group's mask (bits [7:0] of register 1+g).
- R4: A core that belongs to several groups receives stop if any group containing it is triggered, and cores in untriggered groups only stay running.
- R5: A core whose bit is zero in every mask is never stopped. A group whose mask is all zeros never sets its trigger flag (bit 8 of its register).
- R6: Once set, a trigger flag stays set, and holds stop on all members even after their halted inputs fall, until a write to the group register with bit 8 = 1. Stop is low from the first cycle after that write's clock edge.
- R7: The cause field (read bits [12:10] of register 1+g) holds the index of the lowest-numbered member that was halted in the cycle the flag was set.
- R8: While the enable bit (bit 0 of register 0) is clear, `stop_out` is all zeros and no trigger flag becomes set, even while members are halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_in | input | 8 | Per-core debug-halted status, asynchronous |
| stop_out | output | 8 | Per-core forced-stop request |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 9 | Write data |
| rdata | output | 16 | Read data |

## Verification
The bench measures the synchronizer latency edge by edge. A design with one flop too many or too few would raise stop a cycle late or early. It halts members of overlapping groups to catch an output that takes only one group's request, or that stops a core outside every mask. It drops the halted inputs before clearing a flag, to catch a flag that is not sticky or a stop that lingers after the clear. It also halts two members in the same cycle, to catch a cause field that records the highest or last index. Runs with enable clear and with an all-zero mask catch a block that triggers when it should stay quiet.

// File: rtl/halt_sync_xtrig.sv
module halt_sync_xtrig #(
  parameter int NCORES  = 8,
  parameter int NGROUPS = 4,
  parameter int AW      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCORES-1:0] halt_in,
  output logic [NCORES-1:0] stop_out,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [8:0]        wdata,
  output logic [15:0]       rdata
);
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1;

  logic [NCORES-1:0] h1, h2;
  logic en;
  logic [NGROUPS-1:0][NCORES-1:0] mask;
  logic [NGROUPS-1:0] flag;
  logic [NGROUPS-1:0][CW-1:0] cause;

  function automatic logic [CW-1:0] lowest(input logic [NCORES-1:0] v);
    lowest = '0;
    for (int i = NCORES - 1; i >= 0; i--)
      if (v[i]) lowest = CW'(i);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h1 <= '0;
      h2 <= '0;
      en <= 1'b0;
    end else begin
      h1 <= halt_in;
      h2 <= h1;
      if (wr_en && addr == '0) en <= wdata[0];
    end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    wire wsel = wr_en && (addr == AW'(g + 1));
    wire [NCORES-1:0] hits = h2 & mask[g];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mask[g]  <= '0;
        flag[g]  <= 1'b0;
        cause[g] <= '0;
      end else begin
        if (wsel) mask[g] <= wdata[NCORES-1:0];
        if (wsel && wdata[8]) flag[g] <= 1'b0;
        else if (en && |hits && !flag[g]) begin
          flag[g]  <= 1'b1;
          cause[g] <= lowest(hits);
        end
      end
  end

  always_comb begin
    stop_out = '0;
    for (int g = 0; g < NGROUPS; g++)
      if (flag[g]) stop_out = stop_out | mask[g];
    if (!en) stop_out = '0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == '0) rdata[0] = en;
      for (int g = 0; g < NGROUPS; g++)
        if (addr == AW'(g + 1)) begin
          rdata[NCORES-1:0] = mask[g];
          rdata[8]          = flag[g];
          rdata[10 +: CW]   = cause[g];
        end
    end
  end
endmodule

module halt_sync_xtrig_chk #(
  parameter int NCORES  = 8,
  parameter int NGROUPS = 4,
  parameter int AW      = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           en,
  input logic [NGROUPS-1:0][NCORES-1:0] mask,
  input logic [NGROUPS-1:0]             flag,
  input logic [NCORES-1:0]              h2,
  input logic [NCORES-1:0]              stop_out,
  input logic                           wr_en,
  input logic [AW-1:0]                  addr,
  input logic [8:0]                     wdata
);
  logic [NCORES-1:0] all_masks;
  always_comb begin
    all_masks = '0;
    for (int g = 0; g < NGROUPS; g++) all_masks = all_masks | mask[g];
  end

  assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> stop_out == '0);
  assert_nonmember_never_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_out & ~all_masks) == '0);
  assert_stop_needs_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_out != '0 |-> flag != '0);

  for (genvar g = 0; g < NGROUPS; g++) begin : g_chk
    wire wg = wr_en && (addr == AW'(g + 1));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag[g] && !(wg && wdata[8]) |=> flag[g]);
    assert_member_halt_triggers_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en && ((h2 & mask[g]) != '0) && !wg |=> flag[g]);
    assert_empty_group_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flag[g] && mask[g] == '0 |=> !flag[g]);
    assert_no_trigger_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !flag[g] && !en |=> !flag[g]);
  end
endmodule

bind halt_sync_xtrig halt_sync_xtrig_chk #(.NCORES(NCORES), .NGROUPS(NGROUPS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mask(mask), .flag(flag), .h2(h2),
  .stop_out(stop_out), .wr_en(wr_en), .addr(addr), .wdata(wdata));

// File: tb/tb_halt_sync_xtrig.sv
module tb_halt_sync_xtrig;
  logic clk = 0, rst_n = 0;
  logic [7:0] halt_in = '0;
  logic [7:0] stop_out;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [8:0] wdata = '0;
  logic [15:0] rdata;
  int total = 0, bad = 0;

  halt_sync_xtrig dut (.*);

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; halt_in = '0; wr_en = 0; rd_en = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 d = rdata;
    rd_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rst_n = 0;
    wait_cyc(2);
    check(stop_out == 8'h00, "R1 stop in reset", stop_out, 0);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin
      rd(4'(a), d);
      check(d == 16'h0, "R1 register reset", d, 0);
    end
  endtask

  task automatic t_latency();
    do_reset();
    wr(4'd0, 9'h001);
    wr(4'd1, 9'h00F);
    @(negedge clk);
    halt_in = 8'h04;
    @(negedge clk);
    check(stop_out == 8'h00, "R2 after edge 1", stop_out, 0);
    @(negedge clk);
    check(stop_out == 8'h00, "R2 after edge 2", stop_out, 0);
    @(negedge clk);
    check(stop_out == 8'h0F, "R2/R3 after edge 3", stop_out, 8'h0F);
  endtask

  task automatic t_release();
    logic [15:0] d;
    halt_in = '0;
    wait_cyc(4);
    check(stop_out == 8'h0F, "R6 held after halt drops", stop_out, 8'h0F);
    rd(4'd1, d);
    check(d[8] == 1'b1, "R6 flag sticky", d[8], 1);
    @(negedge clk);
    wr_en = 1; addr = 4'd1; wdata = 9'h10F;
    @(negedge clk);
    wr_en = 0;
    check(stop_out == 8'h00, "R6 stop drops after clear", stop_out, 0);
    rd(4'd1, d);
    check(d[8] == 1'b0, "R6 flag cleared", d[8], 0);
    check(d[7:0] == 8'h0F, "R6 mask kept", d[7:0], 8'h0F);
  endtask

  task automatic t_overlap();
    do_reset();
    wr(4'd0, 9'h001);
    wr(4'd1, 9'h003);
    wr(4'd2, 9'h006);
    halt_in = 8'h01;
    wait_cyc(4);
    check(stop_out == 8'h03, "R4 only group 0", stop_out, 8'h03);
    halt_in = 8'h05;
    wait_cyc(4);
    check(stop_out == 8'h07, "R4 union of groups", stop_out, 8'h07);
  endtask

  task automatic t_nonmember();
    logic [15:0] d;
    do_reset();
    wr(4'd0, 9'h001);
    wr(4'd1, 9'h003);
    halt_in = 8'h80;
    wait_cyc(5);
    check(stop_out == 8'h00, "R5 non-member halt ignored", stop_out, 0);
    rd(4'd4, d);
    check(d[8] == 1'b0, "R5 empty group flag", d[8], 0);
    halt_in = 8'h81;
    wait_cyc(4);
    check(stop_out == 8'h03, "R5 non-member not stopped", stop_out, 8'h03);
  endtask

  task automatic t_cause();
    logic [15:0] d;
    do_reset();
    wr(4'd0, 9'h001);
    wr(4'd3, 9'h0A4);
    halt_in = 8'h24;
    wait_cyc(4);
    rd(4'd3, d);
    check(d[12:10] == 3'd2, "R7 lowest cause", d[12:10], 2);
    check(stop_out == 8'hA4, "R3 all members", stop_out, 8'hA4);
    halt_in = 8'h80;
    wait_cyc(4);
    rd(4'd3, d);
    check(d[12:10] == 3'd2, "R7 cause kept while flag set", d[12:10], 2);
  endtask

  task automatic t_disable();
    logic [15:0] d;
    do_reset();
    wr(4'd1, 9'h0FF);
    halt_in = 8'h10;
    wait_cyc(6);
    check(stop_out == 8'h00, "R8 disabled stop", stop_out, 0);
    rd(4'd1, d);
    check(d[8] == 1'b0, "R8 disabled flag", d[8], 0);
    rd(4'd0, d);
    check(d[0] == 1'b0, "R8 enable clear", d[0], 0);
    wr(4'd0, 9'h001);
    wait_cyc(2);
    check(stop_out == 8'hFF, "R8 triggers once enabled", stop_out, 8'hFF);
    wr(4'd0, 9'h000);
    check(stop_out == 8'h00, "R8 stop gated by enable", stop_out, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_release();
        t_overlap();
        t_nonmember();
        t_cause();
        t_disable();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule